// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request from a 32-lane warp. The request carries an active mask and a 32-bit word address for every lane. The block checks whether the active lanes fall inside one aligned 32-word segment, which a single burst from the backing memory can serve. If they do, it issues one burst request: the lowest word touched and the number of words up to and including the highest one.

If the lanes are spread out, the block splits the request. It issues one burst for each distinct segment the active lanes touch. The bursts come out in the order of the lowest-numbered lane that first reaches each segment. Lanes whose mask bit is clear play no part.

Both the request input and the burst output use a valid/ready handshake. No new request is taken while bursts from the current one are still outstanding. After each request, a one-cycle status pulse reports how many bursts it used.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `stat_valid` are 0.
- R2: A lane whose bit in `in_mask` is 0 does not affect any burst, whatever its address. Bit i of `in_mask` and bits [32*i+31:32*i] of `in_addr` belong to lane i.
- R3: If every active lane has the same `addr[31:5]`, the request produces exactly one burst.
- R4: Otherwise the request produces one burst per distinct `addr[31:5]` value among the active lanes. The bursts are ordered by the lowest lane index that hits each segment.
- R5: Each burst has `out_base` equal to the smallest address in its segment among its lanes. `out_len` equals the largest such address minus `out_base`, plus one. `out_last` is 1 only on the request's final burst.
- R6: `in_ready` is 0 from the cycle after a request with a nonzero mask is accepted until the final burst of that request has been handshaken. A request held on the input during that time is not taken.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_base`, `out_len` and `out_last` hold their values into the next cycle.
- R8: `stat_valid` pulses for one cycle right after the final burst handshake, with `stat_count` equal to the number of bursts. A request with an all-zero mask is accepted, issues no burst, and pulses `stat_valid` with `stat_count` 0 in the following cycle.
- R9: Lanes that read the same word are counted once: a warp where every lane reads one word gives a single burst of length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A warp request is offered |
| in_ready | output | 1 | The block can take a request |
| in_mask | input | 32 | Active lanes, one bit per lane |
| in_addr | input | 1024 | Word address per lane, lane i at bits [32*i+31:32*i] |
| out_valid | output | 1 | A burst request is offered |
| out_ready | input | 1 | The memory side takes the burst |
| out_base | output | 32 | First word address of the burst |
| out_len | output | 6 | Burst length in words (1 to 32) |
| out_last | output | 1 | Final burst of the current request |
| stat_valid | output | 1 | Pulse: the request has finished |
| stat_count | output | 6 | Number of bursts the finished request used |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit word addresses and 32-word segments. With these values, a stride-32 pattern spreads a warp over 32 bursts, which drives the transaction counter to its full value. Unaligned runs that straddle a segment boundary, broadcasts to one word, and lanes that revisit an earlier segment are all reachable. Back-to-back requests, with the next one held on the input while random stalls are applied on the output, exercise the input blocking and the output hold.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES     = 32,
  parameter int AW        = 32,
  parameter int SEG_WORDS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES-1:0]      in_mask,
  input  logic [LANES*AW-1:0]   in_addr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [AW-1:0]         out_base,
  output logic [$clog2(SEG_WORDS+1)-1:0] out_len,
  output logic                  out_last,
  output logic                  stat_valid,
  output logic [$clog2(LANES+1)-1:0] stat_count
);
  localparam int SEG_LOG = $clog2(SEG_WORDS);
  localparam int SEG_W   = AW - SEG_LOG;
  localparam int LEN_W   = $clog2(SEG_WORDS+1);
  localparam int CNT_W   = $clog2(LANES+1);

  logic                busy;
  logic [LANES-1:0]    pend;
  logic [AW-1:0]       addr_q [LANES];
  logic [CNT_W-1:0]    tx_cnt;

  logic [SEG_W-1:0]    lead_seg;
  logic [LANES-1:0]    hit;
  logic [SEG_LOG-1:0]  lo_ofs, hi_ofs;
  logic [LANES-1:0]    rest;

  always_comb begin
    logic found;
    found    = 1'b0;
    lead_seg = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && !found) begin
        found    = 1'b1;
        lead_seg = addr_q[i][AW-1:SEG_LOG];
      end
    end
  end

  always_comb begin
    lo_ofs = '1;
    hi_ofs = '0;
    for (int i = 0; i < LANES; i++) begin
      hit[i] = pend[i] && (addr_q[i][AW-1:SEG_LOG] == lead_seg);
      if (hit[i]) begin
        if (addr_q[i][SEG_LOG-1:0] < lo_ofs) lo_ofs = addr_q[i][SEG_LOG-1:0];
        if (addr_q[i][SEG_LOG-1:0] > hi_ofs) hi_ofs = addr_q[i][SEG_LOG-1:0];
      end
    end
  end

  assign rest      = pend & ~hit;
  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_base  = {lead_seg, lo_ofs};
  assign out_len   = LEN_W'(hi_ofs) - LEN_W'(lo_ofs) + LEN_W'(1);
  assign out_last  = (rest == '0);

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      for (int i = 0; i < LANES; i++) addr_q[i] <= in_addr[i*AW +: AW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend       <= '0;
      tx_cnt     <= '0;
      stat_valid <= 1'b0;
      stat_count <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (in_valid && in_ready) begin
        pend   <= in_mask;
        busy   <= |in_mask;
        tx_cnt <= '0;
        if (in_mask == '0) begin
          stat_valid <= 1'b1;
          stat_count <= '0;
        end
      end else if (out_valid && out_ready) begin
        pend   <= rest;
        tx_cnt <= tx_cnt + CNT_W'(1);
        if (out_last) begin
          busy       <= 1'b0;
          stat_valid <= 1'b1;
          stat_count <= tx_cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_base) && $stable(out_len) && $stable(out_last)); // R7
  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mask != '0) |=> !in_ready); // R6
  AST_BUSY_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pend != '0)); // R4
  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(SEG_WORDS))); // R5
  AST_ONE_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_base + AW'(out_len) - AW'(1)) >> SEG_LOG) == (out_base >> SEG_LOG)); // R5
  AST_STAT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> stat_valid && (stat_count != '0)); // R8
  AST_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mask == '0) |=> stat_valid && (stat_count == '0) && !out_valid); // R8
endmodule

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;
  localparam int L = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [L-1:0]  in_mask = '0;
  logic [L*32-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_base;
  logic [5:0]    out_len;
  logic          out_last;
  logic          stat_valid;
  logic [5:0]    stat_count;

  warp_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_base(out_base), .out_len(out_len),
    .out_last(out_last), .stat_valid(stat_valid), .stat_count(stat_count)
  );

  int total = 0, bad = 0;
  logic [31:0] qlo[$];
  logic [31:0] qhi[$];
  logic [31:0] la [L];
  int  ntx = 0, exp_cnt = 0, dut_cnt = -1;
  bit  exp_stat = 0, stall_mode = 0, accepted = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic drive_lanes();
    for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = la[i];
  endtask

  task automatic compare();
    string tag;
    chk("R6 in_ready", 64'(in_ready), 64'(qlo.size() == 0));
    chk("R4 out_valid", 64'(out_valid), 64'(qlo.size() != 0));
    if (qlo.size() != 0) begin
      tag = out_ready ? "R5" : "R7";
      chk(tag, 64'(out_base), 64'(qlo[0]));
      chk(tag, 64'(out_len), 64'(qhi[0] - qlo[0] + 1));
      chk(tag, 64'(out_last), 64'(qlo.size() == 1));
    end
    chk("R8 stat_valid", 64'(stat_valid), 64'(exp_stat));
    if (exp_stat) begin
      chk("R8 stat_count", 64'(stat_count), 64'(exp_cnt));
      dut_cnt = int'(stat_count);
    end
  endtask

  task automatic commit();
    int found;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    exp_stat  = 0;
    accepted  = 0;
    if (qlo.size() != 0) begin
      if (out_ready) begin
        void'(qlo.pop_front());
        void'(qhi.pop_front());
        if (qlo.size() == 0) begin
          exp_stat = 1;
          exp_cnt  = ntx;
        end
      end
    end else if (in_valid) begin
      accepted = 1;
      for (int i = 0; i < L; i++) begin
        if (in_mask[i]) begin
          found = -1;
          for (int j = 0; j < qlo.size(); j++)
            if (qlo[j][31:5] == la[i][31:5]) found = j;
          if (found < 0) begin
            qlo.push_back(la[i]);
            qhi.push_back(la[i]);
          end else begin
            if (la[i] < qlo[found]) qlo[found] = la[i];
            if (la[i] > qhi[found]) qhi[found] = la[i];
          end
        end
      end
      ntx = qlo.size();
      if (ntx == 0) begin
        exp_stat = 1;
        exp_cnt  = 0;
      end
    end
  endtask

  task automatic cycle();
    commit();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input logic [L-1:0] m);
    in_valid = 1'b1;
    in_mask  = m;
    drive_lanes();
    do cycle(); while (!accepted);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (qlo.size() != 0) cycle();
    cycle();
  endtask

  task automatic one(input string tag, input logic [L-1:0] m, input int exp_tx);
    dut_cnt = -1;
    send(m);
    in_valid = 1'b0;
    while (qlo.size() != 0) cycle();
    chk(tag, 64'(dut_cnt), 64'(exp_tx));
    cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R6 watchdog expired: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 stat_valid", 64'(stat_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R3: aligned consecutive run, one burst of 32
    for (int i = 0; i < L; i++) la[i] = 32'h100 + i;
    one("R3 aligned run", '1, 1);

    // R4: unaligned run straddles two segments
    for (int i = 0; i < L; i++) la[i] = 32'h105 + i;
    one("R4 straddle", '1, 2);

    // R4: stride 2 covers two segments
    for (int i = 0; i < L; i++) la[i] = 32'h400 + 2 * i;
    one("R4 stride2", '1, 2);

    // R4: stride 32 gives 32 bursts
    for (int i = 0; i < L; i++) la[i] = 32'h2000 + 32 * i;
    one("R4 stride32", '1, 32);

    // R4: lanes revisit an earlier segment, order by first hit
    for (int i = 0; i < L; i++) la[i] = (i % 3 == 0) ? 32'h900 + i : (i % 3 == 1) ? 32'h40 + i : 32'h7000_0000 + i;
    one("R4 revisit", '1, 3);

    // R2: inactive lanes point far away
    for (int i = 0; i < L; i++) la[i] = (i < 8) ? 32'h300 + i : 32'hF000_0000 + 64 * i;
    one("R2 masked lanes", 32'h0000_00FF, 1);

    // R8: empty mask
    one("R8 empty mask", '0, 0);

    // R9: broadcast to one word
    for (int i = 0; i < L; i++) la[i] = 32'h1234;
    one("R9 broadcast", '1, 1);

    // R7/R6: random patterns, stalls, back-to-back requests
    stall_mode = 1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] b;
      int mode;
      b = $urandom;
      mode = n % 3;
      for (int i = 0; i < L; i++)
        la[i] = (mode == 0) ? b + i : (mode == 1) ? b + ($urandom % 128) : $urandom;
      send(((n % 7) == 0) ? '0 : L'($urandom));
    end
    drain();
    stall_mode = 0;
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule